// File: doc/BRIEF.md
# Multichannel Audio Link Output Frame Formatter

This block assembles the contents of one outgoing audio link frame: a 16-bit tag word followed by twelve 20-bit data slots. At every frame boundary, signalled by a one-cycle `frame_start_i` pulse, it captures a new frame into its output registers. A bit serializer then shifts the frame out. The PCM playback slots are filled according to the channel mode (2, 4 or 6 channels). Every slot that carries nothing is driven with zeros and has its tag bit cleared.

The block also owns the general-purpose control slot (slot 12). This slot carries 16 control bits that software writes to the codec GPIO register, at register index 0x54 of either the primary or the secondary codec. A register write is held until the next frame boundary. That frame carries the write as a command on slots 1 and 2, and it also starts sending the value on slot 12. Slot 12 then keeps repeating the most recent value in every frame until a bus reset, link cold reset, link warm reset or deep-sleep resume event clears it. After such an event, slot 12 stays invalid until software writes the register again.

Top module: `afmt_top`

## Requirements
- R1: The tag and slot outputs change only in the cycle after a clock edge that sees `frame_start_i` high. `frame_load_o` is high in exactly that cycle. Synchronous reset drives every output to zero.
- R2: Slots 3 and 4 carry the front left and front right samples (channels 0 and 1) in every mode. A sample is MSB justified in the 20-bit slot, with its low bits padded with zeros.
- R3: Slots 7 and 8 carry the rear left and rear right samples (channels 3 and 4) in 4-channel mode (`mode_i`=1) and in 6-channel mode (`mode_i`=2). In 2-channel mode (`mode_i`=0) and for the unused code 3, these slots are zero with their tags cleared.
- R4: Slot 6 carries the centre sample (channel 2) and slot 9 carries the subwoofer sample (channel 5), but only in 6-channel mode. In every other mode both slots are zero with their tags cleared.
- R5: Slots 5, 10 and 11 are always zero and their tag bits are always clear.
- R6: The valid bit of slot n is tag bit 15−n. Tag bit 15 is set when any slot is valid. A slot whose valid bit is clear carries all zeros. An enabled channel whose `pcm_vld_i` bit is low gives a clear tag and zero data.
- R7: After reset, slot 12 is invalid (tag bit 3 clear, data zero) in every frame until the first GPIO register write.
- R8: The frame that follows a write carries a command. Slot 1 is 20'h54000: bit 19 = 0 marks a write and bits 18:12 hold index 0x54. Slot 2 holds the write data in bits 19:4. Slot 12 holds the same data in bits 19:4. Tag bits 14, 13 and 3 are set. Slots 1 and 2 are invalid in every frame that has no new write.
- R9: In a command frame, tag bits 1:0 read 01 when the write targeted the secondary codec (`gpio_sec_i`=1) and 00 for the primary codec.
- R10: Once written, slot 12 stays valid in every later frame and repeats the most recently written value.
- R11: A write that arrives between boundaries does not alter the current outputs. When several writes arrive before a boundary, the last one is used. A write in the same cycle as `frame_start_i` appears in the frame captured at that edge.
- R12: Any bit of `link_evt_i` (bus reset, cold reset, warm reset, deep-sleep resume) marks slot 12 invalid from the next frame on and discards any pending write. A write in the same cycle as an event is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame boundary pulse; the next frame is captured at this edge |
| mode_i | input | 2 | Channel mode: 0 = 2 ch, 1 = 4 ch, 2 = 6 ch, 3 = treated as 2 ch |
| pcm_i | input | 6×SAMPLE_W | Samples: 0 front L, 1 front R, 2 centre, 3 rear L, 4 rear R, 5 subwoofer |
| pcm_vld_i | input | 6 | Per-channel sample valid |
| gpio_wr_i | input | 1 | GPIO register write strobe |
| gpio_sec_i | input | 1 | Write targets the secondary codec |
| gpio_wdata_i | input | 16 | GPIO register write data |
| link_evt_i | input | 4 | Invalidation events: bus reset, cold reset, warm reset, resume |
| frame_load_o | output | 1 | New frame present on the outputs |
| tag_o | output | 16 | Slot 0 tag word |
| slot_o | output | 12×20 | Slot data; element k is slot k+1 |

## Verification
Two actions can land in the same clock cycle: a GPIO write and a frame boundary, or a GPIO write and an invalidation event. The bench drives the write strobe in the very cycle that `frame_start_i` is high, and checks that the captured frame already holds the command and the new slot 12 value. It also raises an event together with a write, and checks that the next frame still shows slot 12 valid with the new data. By contrast, an event raised after a write, but before the boundary, must leave slot 12 invalid with no command.

// File: rtl/afmt_pkg.sv
`timescale 1ns/1ps
package afmt_pkg;

    localparam int SLOT_W    = 20;
    localparam int NSLOT     = 12;
    localparam int TAG_W     = 16;
    localparam int GPIO_W    = 16;
    localparam int NCH       = 6;
    localparam int EVT_W     = 4;
    localparam int REG_IDX_W = 7;
    localparam logic [REG_IDX_W-1:0] GPIO_REG_IDX = 7'h54;

    typedef enum logic [1:0] {
        MODE_2CH = 2'd0,
        MODE_4CH = 2'd1,
        MODE_6CH = 2'd2,
        MODE_RSV = 2'd3
    } chan_mode_e;

    typedef logic [SLOT_W-1:0] slot_word_t;

    typedef struct packed {
        logic              vld;
        logic              sec;
        logic [GPIO_W-1:0] data;
    } gpio_cmd_t;

    // Slot number (1..12) that carries a given channel index
    function automatic int chan_slot(input int ch);
        case (ch)
            0:       return 3;
            1:       return 4;
            2:       return 6;
            3:       return 7;
            4:       return 8;
            default: return 9;
        endcase
    endfunction

    // Whether a channel is carried in the selected mode
    function automatic logic chan_on(input chan_mode_e m, input int ch);
        case (ch)
            0, 1:    return 1'b1;
            3, 4:    return (m == MODE_4CH) || (m == MODE_6CH);
            default: return (m == MODE_6CH);
        endcase
    endfunction

    function automatic slot_word_t gpio_word(input logic [GPIO_W-1:0] d);
        return slot_word_t'(d) << (SLOT_W - GPIO_W);
    endfunction

    function automatic slot_word_t cmd_addr_word();
        return slot_word_t'({1'b0, GPIO_REG_IDX}) << (SLOT_W - 1 - REG_IDX_W);
    endfunction

endpackage

// File: rtl/afmt_pcm_map.sv
`timescale 1ns/1ps
module afmt_pcm_map
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  chan_mode_e                      mode,
    input  logic [NCH-1:0][SAMPLE_W-1:0]    pcm,
    input  logic [NCH-1:0]                  pcm_vld,
    output slot_word_t [NCH-1:0]            ch_word,
    output logic [NCH-1:0]                  ch_tag
);
    localparam int PAD_W = SLOT_W - SAMPLE_W;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic en;
            always_comb begin
                en          = chan_on(mode, ch) && pcm_vld[ch];
                ch_tag[ch]  = en;
                ch_word[ch] = en ? (slot_word_t'(pcm[ch]) << PAD_W) : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/afmt_gpio_slot.sv
`timescale 1ns/1ps
module afmt_gpio_slot
    import afmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              wr,
    input  logic              sec,
    input  logic [GPIO_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    output gpio_cmd_t         cmd_nxt,
    output logic              s12_vld_nxt,
    output logic [GPIO_W-1:0] s12_data_nxt
);
    gpio_cmd_t         pend_q, pend_eff;
    logic              s12_vld_q, s12_vld_eff;
    logic [GPIO_W-1:0] s12_data_q;
    logic              any_evt;

    always_comb begin
        any_evt = |evt;
        if (wr) begin
            pend_eff.vld  = 1'b1;
            pend_eff.sec  = sec;
            pend_eff.data = wdata;
        end else if (any_evt) begin
            pend_eff = '0;
        end else begin
            pend_eff = pend_q;
        end
        s12_vld_eff  = any_evt ? 1'b0 : s12_vld_q;
        cmd_nxt      = pend_eff;
        s12_vld_nxt  = pend_eff.vld || s12_vld_eff;
        s12_data_nxt = pend_eff.vld ? pend_eff.data : s12_data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            s12_vld_q  <= 1'b0;
            s12_data_q <= '0;
        end else if (frame_start) begin
            pend_q     <= '0;
            s12_vld_q  <= s12_vld_nxt;
            s12_data_q <= s12_data_nxt;
        end else begin
            pend_q     <= pend_eff;
            s12_vld_q  <= s12_vld_eff;
        end
    end
endmodule

// File: rtl/afmt_top.sv
`timescale 1ns/1ps
module afmt_top
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frame_start_i,
    input  logic [1:0]                      mode_i,
    input  logic [NCH-1:0][SAMPLE_W-1:0]    pcm_i,
    input  logic [NCH-1:0]                  pcm_vld_i,
    input  logic                            gpio_wr_i,
    input  logic                            gpio_sec_i,
    input  logic [GPIO_W-1:0]               gpio_wdata_i,
    input  logic [EVT_W-1:0]                link_evt_i,
    output logic                            frame_load_o,
    output logic [TAG_W-1:0]                tag_o,
    output logic [NSLOT-1:0][SLOT_W-1:0]    slot_o
);
    slot_word_t [NCH-1:0]   ch_word;
    logic [NCH-1:0]         ch_tag;
    gpio_cmd_t              cmd_nxt;
    logic                   s12_vld_nxt;
    logic [GPIO_W-1:0]      s12_data_nxt;

    slot_word_t [NSLOT-1:0] nxt_slot;
    logic [NSLOT-1:0]       nxt_vld;
    logic [TAG_W-1:0]       nxt_tag;

    afmt_pcm_map #(.SAMPLE_W(SAMPLE_W)) u_map (
        .mode    (chan_mode_e'(mode_i)),
        .pcm     (pcm_i),
        .pcm_vld (pcm_vld_i),
        .ch_word (ch_word),
        .ch_tag  (ch_tag)
    );

    afmt_gpio_slot u_gpio (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start_i),
        .wr           (gpio_wr_i),
        .sec          (gpio_sec_i),
        .wdata        (gpio_wdata_i),
        .evt          (link_evt_i),
        .cmd_nxt      (cmd_nxt),
        .s12_vld_nxt  (s12_vld_nxt),
        .s12_data_nxt (s12_data_nxt)
    );

    always_comb begin
        nxt_slot = '0;
        nxt_vld  = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_slot[chan_slot(ch)-1] = ch_word[ch];
            nxt_vld[chan_slot(ch)-1]  = ch_tag[ch];
        end
        if (cmd_nxt.vld) begin
            nxt_slot[0] = cmd_addr_word();
            nxt_slot[1] = gpio_word(cmd_nxt.data);
            nxt_vld[0]  = 1'b1;
            nxt_vld[1]  = 1'b1;
        end
        if (s12_vld_nxt) begin
            nxt_slot[NSLOT-1] = gpio_word(s12_data_nxt);
            nxt_vld[NSLOT-1]  = 1'b1;
        end
        nxt_tag          = '0;
        nxt_tag[TAG_W-1] = |nxt_vld;
        for (int s = 0; s < NSLOT; s++) begin
            nxt_tag[TAG_W-2-s] = nxt_vld[s];
        end
        nxt_tag[1:0] = (cmd_nxt.vld && cmd_nxt.sec) ? 2'b01 : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_load_o <= 1'b0;
            tag_o        <= '0;
            slot_o       <= '0;
        end else begin
            frame_load_o <= frame_start_i;
            if (frame_start_i) begin
                tag_o  <= nxt_tag;
                slot_o <= nxt_slot;
            end
        end
    end
endmodule

// File: rtl/afmt_checker.sv
`timescale 1ns/1ps
module afmt_checker
    import afmt_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   mode_i,
    input logic                         frame_load_o,
    input logic [TAG_W-1:0]             tag_o,
    input logic [NSLOT-1:0][SLOT_W-1:0] slot_o
);
    assert_hold_between_frames_R1: assert property (@(posedge clk) disable iff (rst)
        !frame_load_o |-> ($stable(slot_o) && $stable(tag_o)));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_o[4] == '0) && (slot_o[9] == '0) && (slot_o[10] == '0)
        && !tag_o[10] && !tag_o[5] && !tag_o[4]);

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_gate
            assert_tag_gates_data_R6: assert property (@(posedge clk) disable iff (rst)
                !tag_o[TAG_W-2-g] |-> (slot_o[g] == '0));
        end
    endgenerate

    assert_cmd_with_slot12_R8: assert property (@(posedge clk) disable iff (rst)
        tag_o[14] |-> (tag_o[13] && tag_o[3] && (slot_o[1] == slot_o[11])));

    assert_centre_sub_6ch_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_load_o && ($past(mode_i) != 2'd2)) |-> (!tag_o[9] && !tag_o[6]));

    assert_rear_off_2ch_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_load_o && (($past(mode_i) == 2'd0) || ($past(mode_i) == 2'd3)))
        |-> (!tag_o[8] && !tag_o[7]));
endmodule

bind afmt_top afmt_checker u_chk (.*);

// File: tb/test_afmt_top.sv
`timescale 1ns/1ps
module test_afmt_top;
    localparam int SW = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [5:0][SW-1:0] pcm;
    logic [5:0]        pcm_vld = '0;
    logic              wr = 1'b0;
    logic              sec = 1'b0;
    logic [15:0]       wdata = '0;
    logic [3:0]        evt = '0;
    logic              frame_load;
    logic [15:0]       tag;
    logic [11:0][19:0] slot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    afmt_top #(.SAMPLE_W(SW)) i_afmt_top (
        .clk(clk), .rst(rst), .frame_start_i(frame_start), .mode_i(mode),
        .pcm_i(pcm), .pcm_vld_i(pcm_vld), .gpio_wr_i(wr), .gpio_sec_i(sec),
        .gpio_wdata_i(wdata), .link_evt_i(evt), .frame_load_o(frame_load),
        .tag_o(tag), .slot_o(slot)
    );

    // {mode[1:0], vld[5:0], expected tag bits 12..6 (slots 3..9)}
    localparam logic [14:0] VEC [8] = '{
        {2'd0, 6'h3F, 7'h60},
        {2'd1, 6'h3F, 7'h66},
        {2'd2, 6'h3F, 7'h6F},
        {2'd3, 6'h3F, 7'h60},
        {2'd2, 6'h15, 7'h4A},
        {2'd1, 6'h2A, 7'h24},
        {2'd2, 6'h00, 7'h00},
        {2'd0, 6'h03, 7'h60}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic gpio_write(input logic s, input logic [15:0] d);
        @(negedge clk) begin wr = 1'b1; sec = s; wdata = d; end
        @(negedge clk) wr = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        @(negedge clk) evt = e;
        @(negedge clk) evt = '0;
    endtask

    function automatic logic [19:0] exp_pcm(input int s, input logic tb);
        int ch;
        case (s)
            3: ch = 0; 4: ch = 1; 6: ch = 2; 7: ch = 3; 8: ch = 4; default: ch = 5;
        endcase
        return tb ? {pcm[ch], 4'h0} : 20'h0;
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        pcm = {16'hF006, 16'hE005, 16'hD004, 16'hC003, 16'hB002, 16'hA001};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 reset tag", 32'(tag), 32'h0);
        chk("R1 reset slots", 32'(slot == '0), 32'h1);
        chk("R1 reset load", 32'(frame_load), 32'h0);

        // Mode/valid table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            logic [6:0] et;
            mode    = VEC[v][14:13];
            pcm_vld = VEC[v][12:7];
            et      = VEC[v][6:0];
            do_frame();
            chk("R1 load pulse", 32'(frame_load), 32'h1);
            chk("R3 R4 R6 pcm tags", 32'(tag[12:6]), 32'(et));
            chk("R6 frame bit", 32'(tag[15]), 32'(|et));
            chk("R7 slot12 invalid", 32'(tag[3]), 32'h0);
            chk("R2 slot3", 32'(slot[2]), 32'(exp_pcm(3, et[6])));
            chk("R2 slot4", 32'(slot[3]), 32'(exp_pcm(4, et[5])));
            chk("R5 slot5", 32'(slot[4]), 32'h0);
            chk("R4 slot6", 32'(slot[5]), 32'(exp_pcm(6, et[3])));
            chk("R3 slot7", 32'(slot[6]), 32'(exp_pcm(7, et[2])));
            chk("R3 slot8", 32'(slot[7]), 32'(exp_pcm(8, et[1])));
            chk("R4 slot9", 32'(slot[8]), 32'(exp_pcm(9, et[0])));
            chk("R5 slot10 11", 32'(slot[9] | slot[10]), 32'h0);
        end

        // R1 hold: inputs change, no boundary
        @(negedge clk) begin mode = 2'd2; pcm_vld = 6'h3F; end
        repeat (3) @(negedge clk);
        chk("R1 hold tag", 32'(tag[12:6]), 32'h60);
        chk("R1 load low", 32'(frame_load), 32'h0);

        mode = 2'd0; pcm_vld = '0;
        do_frame();
        chk("R7 no write yet", 32'(tag), 32'h0);

        // R11 mid-frame write does not touch current outputs
        gpio_write(1'b0, 16'hA5C3);
        chk("R11 current frame unchanged", 32'(tag), 32'h0);
        do_frame();
        chk("R8 tag", 32'(tag), 32'hE008);
        chk("R8 slot1", 32'(slot[0]), 32'h54000);
        chk("R8 slot2", 32'(slot[1]), 32'hA5C30);
        chk("R8 slot12", 32'(slot[11]), 32'hA5C30);
        chk("R9 primary id", 32'(tag[1:0]), 32'h0);

        do_frame();
        chk("R10 repeat tag", 32'(tag), 32'h8008);
        chk("R8 no cmd slot1", 32'(slot[0]), 32'h0);
        chk("R8 no cmd slot2", 32'(slot[1]), 32'h0);
        chk("R10 repeat data", 32'(slot[11]), 32'hA5C30);

        // R11 last write wins, R9 secondary id
        gpio_write(1'b0, 16'h1111);
        gpio_write(1'b1, 16'h2222);
        do_frame();
        chk("R9 secondary tag", 32'(tag), 32'hE009);
        chk("R11 last write slot12", 32'(slot[11]), 32'h22220);
        chk("R11 last write slot2", 32'(slot[1]), 32'h22220);

        // R11 write coincident with boundary
        @(negedge clk) begin frame_start = 1'b1; wr = 1'b1; sec = 1'b0; wdata = 16'h3333; end
        @(negedge clk) begin frame_start = 1'b0; wr = 1'b0; end
        chk("R11 coincident tag", 32'(tag), 32'hE008);
        chk("R11 coincident slot12", 32'(slot[11]), 32'h33330);

        // R12 each event source
        for (int b = 0; b < 4; b++) begin
            gpio_write(1'b0, 16'h4000 + 16'(b));
            do_frame();
            chk("R12 revalidated", 32'(tag), 32'hE008);
            pulse_evt(4'(1 << b));
            do_frame();
            chk("R12 event invalidates tag", 32'(tag), 32'h0);
            chk("R12 event slot12 zero", 32'(slot[11]), 32'h0);
            do_frame();
            chk("R12 stays invalid", 32'(tag), 32'h0);
        end

        // R12 pending write dropped by later event
        gpio_write(1'b0, 16'h5555);
        pulse_evt(4'h2);
        do_frame();
        chk("R12 pending dropped", 32'(tag), 32'h0);

        // R12 event and write together: write kept
        @(negedge clk) begin evt = 4'h8; wr = 1'b1; sec = 1'b0; wdata = 16'h6666; end
        @(negedge clk) begin evt = '0; wr = 1'b0; end
        do_frame();
        chk("R12 same-cycle write tag", 32'(tag), 32'hE008);
        chk("R12 same-cycle write data", 32'(slot[11]), 32'h66660);

        // R1 R7 reset mid-run
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset tag", 32'(tag), 32'h0);
        do_frame();
        chk("R7 invalid after reset", 32'(tag), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule